// File: doc/BRIEF.md
# Three-Wire Banked Register Access Slave

This block is the serial front end of a small register file. A host frames every transfer by raising a chip-enable line, then clocks bits over a single bidirectional data line. The first nibble of a frame chooses both the direction (write or read) and one of two banks. The second nibble gives a starting register address within the 16-entry bank. After that, whole bytes move between the host and the register file, least significant bit first, and the address steps forward by one after every byte.

The block owns no register contents. It presents a plain register-file port (bank, address, write data, a write strobe, read data) and a data output with a separate output enable, so the pad or a parent block can build the tri-state line. Every frame is independent: dropping chip-enable returns the interface to the start of a new frame and discards any write byte that has not been completed.

Top module: `tw3_slave`

## Requirements
- R1: While `ce` is low the output enable `sdOe` is 0, `regWe` is never asserted and shift-clock or data activity leaves no effect on the register file.
- R2: After `ce` rises, serial bits 0 to 3 form the mode code and bits 4 to 7 form the start address; both fields and all data bytes are transferred least significant bit first.
- R3: Mode code 3h writes bank 0, 1h writes bank 1, Ch reads bank 0 and 8h reads bank 1; `regBank` is 0 for bank 0 and 1 for bank 1.
- R4: Any other mode code makes the rest of the frame ignored: no write strobe and `sdOe` stays 0 until `ce` falls.
- R5: In a write frame `sdIn` is sampled on rising `sclk` edges; `regWe` is a single-cycle strobe valid over the rising edge that captures bit 7 of a byte, with the whole byte on `regWdata`. A read frame never asserts `regWe`.
- R6: After each complete byte the register address increments by one, wrapping from Fh to 0h within the selected bank.
- R7: A write byte that has not received all 8 bits when `ce` falls is discarded and never strobed.
- R8: In a read frame `sdOe` turns on at the first falling `sclk` edge after the address nibble; the addressed register is fetched at that edge and shifted out bit 0 first, one bit per falling edge, and the next register is fetched at the falling edge after bit 7.
- R9: Bit counters and mode state clear while `ce` is low, so each new frame starts by decoding a mode code even if the previous frame was cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ce | input | 1 | Frame enable; low clears all frame state |
| sclk | input | 1 | Serial shift clock |
| sdIn | input | 1 | Serial data from the host |
| sdOut | output | 1 | Serial data to the host |
| sdOe | output | 1 | Output enable for the data line |
| regBank | output | 1 | Selected bank |
| regAddr | output | 4 | Register address |
| regWdata | output | 8 | Byte to write |
| regWe | output | 1 | Write strobe, sampled on rising `sclk` |
| regRdata | input | 8 | Byte read from the addressed register |

## Verification
On every clock the assertions watch the frame-level invariants: an illegal code keeps the frame in its ignore state, the write strobe never lasts two edges, the byte offset advances exactly once per committed byte, the output enable never drops inside a read frame and never coexists with a write strobe. Whether bytes land at the right addresses in the right bank, whether bits come out in order on the falling edges, whether a cut-off byte is really lost and whether a fresh frame recovers after an aborted one can only be shown by the bench's frame scenarios against its own register model.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

  typedef enum logic [2:0] {
    PH_MODE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic addrLoad;
    logic wrCommit;
    logic rdActive;
  } strobe_t;

endpackage

// File: rtl/tw3_ctrl.sv
module tw3_ctrl
  import tw3_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [CODE_W-1:0] WR0_CODE = 4'h3,
  parameter logic [CODE_W-1:0] WR1_CODE = 4'h1,
  parameter logic [CODE_W-1:0] RD0_CODE = 4'hC,
  parameter logic [CODE_W-1:0] RD1_CODE = 4'h8
) (
  input  logic              ce,
  input  logic              sclk,
  input  logic [CODE_W-1:0] modeCode,
  output strobe_t           strb,
  output logic              bankSel,
  output logic              readSel
);

  localparam int HDR_W = CODE_W + ADDR_W;
  localparam int MAX_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             codeLegal;
  logic             codeRead;
  logic             codeBank;

  // Mode code decode: direction and bank share one nibble
  always_comb begin
    codeLegal = 1'b1;
    codeRead  = 1'b0;
    codeBank  = 1'b0;
    if (modeCode == WR0_CODE) begin
      codeBank = 1'b0;
    end else if (modeCode == WR1_CODE) begin
      codeBank = 1'b1;
    end else if (modeCode == RD0_CODE) begin
      codeRead = 1'b1;
    end else if (modeCode == RD1_CODE) begin
      codeRead = 1'b1;
      codeBank = 1'b1;
    end else begin
      codeLegal = 1'b0;
    end
  end

  always_ff @(posedge sclk or negedge ce) begin
    if (!ce) begin
      phase   <= PH_MODE;
      bitCnt  <= '0;
      bankSel <= 1'b0;
      readSel <= 1'b0;
    end else begin
      case (phase)
        PH_MODE: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == MODE_LAST) begin
            if (codeLegal) begin
              phase   <= PH_ADDR;
              bankSel <= codeBank;
              readSel <= codeRead;
            end else begin
              phase <= PH_IGNORE;
            end
          end
        end
        PH_ADDR: begin
          if (bitCnt == HDR_LAST) begin
            bitCnt <= '0;
            phase  <= readSel ? PH_READ : PH_WRITE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_WRITE: begin
          bitCnt <= (bitCnt == BYTE_LAST) ? '0 : bitCnt + 1'b1;
        end
        default: begin
        end
      endcase
    end
  end

  assign strb.addrLoad = (phase == PH_ADDR) && (bitCnt == HDR_LAST);
  assign strb.wrCommit = ce && (phase == PH_WRITE) && (bitCnt == BYTE_LAST);
  assign strb.rdActive = (phase == PH_READ);

  AST_IGNORE_STICKY: assert property (@(posedge sclk) disable iff (!ce)
    phase == PH_IGNORE |=> phase == PH_IGNORE) else $error("ignore state left"); // R4
  AST_WE_SINGLE: assert property (@(posedge sclk) disable iff (!ce)
    strb.wrCommit |=> !strb.wrCommit) else $error("write strobe too long"); // R5
  AST_READ_HELD: assert property (@(posedge sclk) disable iff (!ce)
    phase == PH_READ |=> phase == PH_READ && $stable(bankSel)) else $error("read frame left"); // R8

endmodule

// File: rtl/tw3_datapath.sv
module tw3_datapath
  import tw3_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdIn,
  input  strobe_t           strb,
  input  logic              readSel,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] incoming,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              sdOut,
  output logic              sdOe
);

  localparam int RC_W = $clog2(DATA_W);
  localparam logic [RC_W-1:0] RD_LAST = RC_W'(DATA_W - 1);

  logic [DATA_W-1:0] inShift;
  logic [ADDR_W-1:0] hdrAddr;
  logic [ADDR_W-1:0] wrByte;
  logic [ADDR_W-1:0] rdByte;
  logic [RC_W-1:0]   rdCnt;
  logic [DATA_W-1:0] rdShift;
  logic              oeReg;

  // LSB-first: each new bit enters at the top and moves down
  assign incoming = {sdIn, inShift[DATA_W-1:1]};
  assign regWdata = incoming;
  assign regAddr  = hdrAddr + (readSel ? rdByte : wrByte);
  assign sdOut    = rdShift[0];
  assign sdOe     = oeReg;

  always_ff @(posedge sclk or negedge ce) begin
    if (!ce) begin
      inShift <= '0;
      hdrAddr <= '0;
      wrByte  <= '0;
    end else begin
      inShift <= incoming;
      if (strb.addrLoad) hdrAddr <= incoming[DATA_W-1 -: ADDR_W];
      if (strb.wrCommit) wrByte <= wrByte + 1'b1;
    end
  end

  // Read side runs on the falling edge
  always_ff @(negedge sclk or negedge ce) begin
    if (!ce) begin
      oeReg   <= 1'b0;
      rdCnt   <= '0;
      rdByte  <= '0;
      rdShift <= '0;
    end else if (strb.rdActive) begin
      oeReg <= 1'b1;
      if (rdCnt == '0) rdShift <= regRdata;
      else             rdShift <= rdShift >> 1;
      if (rdCnt == RD_LAST) begin
        rdCnt  <= '0;
        rdByte <= rdByte + 1'b1;
      end else begin
        rdCnt <= rdCnt + 1'b1;
      end
    end
  end

  AST_WR_STEP: assert property (@(posedge sclk) disable iff (!ce)
    strb.wrCommit |=> wrByte == ADDR_W'($past(wrByte) + 1)) else $error("write offset step"); // R6
  AST_OE_HELD: assert property (@(negedge sclk) disable iff (!ce)
    oeReg |=> oeReg) else $error("output enable dropped"); // R8
  AST_WR_NO_OE: assert property (@(posedge sclk) disable iff (!ce)
    strb.wrCommit |-> !oeReg) else $error("write while driving"); // R5

endmodule

// File: rtl/tw3_slave.sv
module tw3_slave
  import tw3_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              regBank,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  strobe_t           strb;
  logic              readSel;
  logic [DATA_W-1:0] incoming;

  tw3_ctrl #(
    .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .ce(ce), .sclk(sclk),
    .modeCode(incoming[DATA_W-1 -: CODE_W]),
    .strb(strb), .bankSel(regBank), .readSel(readSel)
  );

  tw3_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dp (
    .ce(ce), .sclk(sclk), .sdIn(sdIn), .strb(strb), .readSel(readSel),
    .regRdata(regRdata), .incoming(incoming), .regAddr(regAddr),
    .regWdata(regWdata), .sdOut(sdOut), .sdOe(sdOe)
  );

  assign regWe = strb.wrCommit;

endmodule

// File: tb/test_tw3_slave.sv
`timescale 1ns/1ps
module test_tw3_slave;

  logic       ce = 1'b0;
  logic       sclk = 1'b0;
  logic       sdIn = 1'b0;
  logic       sdOut, sdOe, regBank, regWe;
  logic [3:0] regAddr;
  logic [7:0] regWdata, regRdata;

  logic [7:0] mem [2][16];
  int weCount = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 sclk = ~sclk;  // 125 MHz

  tw3_slave i_tw3_slave (
    .ce(ce), .sclk(sclk), .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe),
    .regBank(regBank), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  assign regRdata = mem[regBank][regAddr];

  // Register model: capture 1 ns before each rising edge
  always begin
    @(negedge sclk);
    #3;
    if (regWe === 1'b1) begin
      mem[regBank][regAddr] = regWdata;
      weCount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdIn = v[i];
      @(negedge sclk);
      #1;
    end
  endtask

  task automatic beginFrame();
    @(negedge sclk);
    #1;
    ce = 1'b1;
  endtask

  task automatic endFrame();
    ce = 1'b0;
    sdIn = 1'b0;
    @(negedge sclk);
    #1;
  endtask

  task automatic readByteCheck(input logic [7:0] exp, input string req);
    logic [7:0] got;
    bit oeOk = 1;
    for (int i = 0; i < 8; i++) begin
      got[i] = sdOut;
      if (sdOe !== 1'b1) oeOk = 0;
      @(negedge sclk);
      #1;
    end
    check(got === exp, req, got, exp);
    check(oeOk, "R8 oe held", oeOk, 1);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 12; i++) begin
      sdIn = i[0];
      @(negedge sclk);
      #1;
      check(sdOe === 1'b0, "R1 idle oe", sdOe, 0);
    end
    check(weCount == 0, "R1 idle writes", weCount, 0);
  endtask

  task automatic testWriteBank0();
    int w0 = weCount;
    beginFrame();
    sendBits(8'h3, 4); sendBits(8'h5, 4);
    sendBits(8'hA5, 8); sendBits(8'h3C, 8);
    endFrame();
    check(mem[0][5] == 8'hA5, "R2 R5 byte0", mem[0][5], 8'hA5);
    check(mem[0][6] == 8'h3C, "R6 byte1", mem[0][6], 8'h3C);
    check(mem[1][5] == 8'h00, "R3 other bank", mem[1][5], 0);
    check(weCount == w0 + 2, "R5 strobe count", weCount - w0, 2);
  endtask

  task automatic testWriteBank1Wrap();
    beginFrame();
    sendBits(8'h1, 4); sendBits(8'hF, 4);
    sendBits(8'h81, 8); sendBits(8'h7E, 8);
    endFrame();
    check(mem[1][15] == 8'h81, "R3 bank1 write", mem[1][15], 8'h81);
    check(mem[1][0] == 8'h7E, "R6 wrap", mem[1][0], 8'h7E);
    check(mem[0][15] == 8'h00, "R3 bank0 untouched", mem[0][15], 0);
  endtask

  task automatic testReadBank0();
    int w0 = weCount;
    mem[0][14] = 8'h5A; mem[0][15] = 8'hC3; mem[0][0] = 8'h0F;
    beginFrame();
    sendBits(8'hC, 4); sendBits(8'hE, 3);
    check(sdOe === 1'b0, "R8 oe off in header", sdOe, 0);
    sendBits(8'h1, 1);
    check(sdOe === 1'b1, "R8 oe on after address", sdOe, 1);
    readByteCheck(8'h5A, "R8 read first");
    readByteCheck(8'hC3, "R6 read next");
    readByteCheck(8'h0F, "R6 read wrap");
    endFrame();
    check(sdOe === 1'b0, "R1 oe off after frame", sdOe, 0);
    check(weCount == w0, "R5 read never writes", weCount - w0, 0);
  endtask

  task automatic testReadBank1();
    mem[1][3] = 8'h96; mem[0][3] = 8'h11;
    beginFrame();
    sendBits(8'h8, 4); sendBits(8'h3, 4);
    readByteCheck(8'h96, "R3 bank1 read");
    endFrame();
  endtask

  task automatic testIllegal(input logic [3:0] code);
    int w0 = weCount;
    bit oeOk = 1;
    beginFrame();
    sendBits({4'h0, code}, 4); sendBits(8'h2, 4);
    for (int i = 0; i < 16; i++) begin
      sdIn = 1'b1;
      @(negedge sclk);
      #1;
      if (sdOe !== 1'b0) oeOk = 0;
    end
    endFrame();
    check(oeOk, "R4 oe stays off", oeOk, 1);
    check(weCount == w0, "R4 no writes", weCount - w0, 0);
  endtask

  task automatic testPartial();
    int w0 = weCount;
    mem[0][9] = 8'h00; mem[0][10] = 8'h44;
    beginFrame();
    sendBits(8'h3, 4); sendBits(8'h9, 4);
    sendBits(8'h11, 8); sendBits(8'hEE, 5);
    endFrame();
    check(mem[0][9] == 8'h11, "R7 full byte kept", mem[0][9], 8'h11);
    check(mem[0][10] == 8'h44, "R7 partial dropped", mem[0][10], 8'h44);
    check(weCount == w0 + 1, "R7 strobe count", weCount - w0, 1);
  endtask

  task automatic testAbortThenWrite();
    beginFrame();
    sendBits(8'hC, 4); sendBits(8'h0, 4);
    sendBits(8'h0, 3);
    endFrame();
    check(sdOe === 1'b0, "R1 oe cleared", sdOe, 0);
    beginFrame();
    sendBits(8'h3, 4); sendBits(8'h2, 4);
    sendBits(8'h77, 8);
    endFrame();
    check(mem[0][2] == 8'h77, "R9 fresh frame", mem[0][2], 8'h77);
  endtask

  task automatic testCeLowActivity();
    int w0 = weCount;
    logic [7:0] pat = 8'h53;
    for (int k = 0; k < 3; k++) sendBits(pat, 8);
    check(weCount == w0, "R1 ce low no writes", weCount - w0, 0);
    check(sdOe === 1'b0, "R1 ce low oe", sdOe, 0);
    check(mem[0][5] == 8'hA5, "R1 ce low state kept", mem[0][5], 8'hA5);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) mem[b][a] = 8'h00;
    @(negedge sclk);
    #1;
    check(sdOe === 1'b0, "R1 reset oe", sdOe, 0);
    check(regWe === 1'b0, "R1 reset we", regWe, 0);
    testIdle();
    testWriteBank0();
    testWriteBank1Wrap();
    testReadBank0();
    testReadBank1();
    testIllegal(4'h5);
    testIllegal(4'hB);
    testPartial();
    testAbortThenWrite();
    testCeLowActivity();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule